// File: doc/BRIEF.md
# Banked Vertical Timing Register File

This block is the control-register store for the vertical timing of a video decoder. It holds three 10-bit absolute line numbers: the line where vertical sync ends, the line where vertical blanking begins, and the line where vertical blanking ends. It also holds a signed 8-bit line offset for the embedded field and vertical flags. A host reaches the registers through a plain byte-wide address, data and write-strobe port. Writes complete in the cycle they are presented. The port never stalls, so there is no back-pressure to manage. Reads are combinational on the address.

Each timing value has one copy per video standard. A standard-select register chooses the bank that host writes land in. The same register chooses the bank whose values drive the continuous timing outputs. Each 10-bit value is split into a low byte and a high byte. A low-byte write only stages its byte. The high-byte write commits both parts at once, so a downstream timing generator never sees a half-updated line number.

Top module: `vtr_regfile`

## Requirements
- R1: After reset the standard select is 0, the offset is 00h, and every bank holds its line-standard default. Even banks (0 and 2) use the 525-line set: sync end 004h, blank start 001h, blank end 001h. Odd banks (1 and 3) use the 625-line set: sync end 001h, blank start 26Fh, blank end 26Fh.
- R2: A write to 02h loads bits [1:0] as the standard select. Reading 02h returns the select in bits [1:0] and zero in bits [7:2]. The select picks the bank shown on the outputs and the bank that host writes target.
- R3: Each timing value has a low-byte address and a high-byte address: sync end at 20h/21h, blank start at 22h/23h, blank end at 24h/25h. A high-byte write commits {wdata[1:0], staged low byte} into the selected bank. The new value appears on the outputs after that clock edge. Bits [7:2] of the high byte are ignored.
- R4: A low-byte write on its own does not change any committed value or output.
- R5: Banks are independent. A commit in one bank leaves every other bank unchanged, and each bank keeps its values until reset.
- R6: Reading a low-byte address returns the committed low byte of the selected bank, never the staged byte. Reading a high-byte address returns committed bits [9:8] in bits [1:0], with bits [7:2] as zero.
- R7: Address 26h holds the offset as an 8-bit two's-complement line count (-128 to +127). It reads back as written and drives `sync_offset`.
- R8: A write to 02h that changes the select discards all staged low bytes. A later high-byte write then keeps the committed low byte of its bank.
- R9: A high-byte write with no staged low byte since the last commit keeps that bank's committed low byte.
- R10: Writes to addresses other than 02h and 20h–26h have no effect. Reads of those addresses return 00h.
- R11: The timing outputs change only at the clock edge of a high-byte write or of a select change. `sync_offset` changes only at the edge of a write to 26h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address and data |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| std_sel | output | 2 | Current standard select (bank index) |
| vs_end_line | output | 10 | Committed sync-end line of the selected bank |
| vb_start_line | output | 10 | Committed blank-start line of the selected bank |
| vb_end_line | output | 10 | Committed blank-end line of the selected bank |
| sync_offset | output | 8 | Signed embedded-flag line offset |

## Verification
A wrong staged byte stays hidden until the next high-byte write. It then appears on a timing output one edge later, so the bench commits after each staging pattern. A wrong bank word, for example one written to the wrong bank or one lost at reset, shows only once that bank is selected. The bench therefore walks every bank and compares the outputs and readback against its model on every clock. A stale pending flag appears only after a select change followed by a high-byte write, and that order is exercised on purpose.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
  localparam int DW = 8;
  localparam int LW = 10;
  localparam int NFIELD = 3;

  localparam logic [DW-1:0] A_STD    = 8'h02;
  localparam logic [DW-1:0] A_VSE_LO = 8'h20;
  localparam logic [DW-1:0] A_VBS_LO = 8'h22;
  localparam logic [DW-1:0] A_VBE_LO = 8'h24;
  localparam logic [DW-1:0] A_OFS    = 8'h26;

  typedef enum int {F_VSE = 0, F_VBS = 1, F_VBE = 2} field_e;

  // Odd banks carry the 625-line set, even banks the 525-line set.
  function automatic logic [LW-1:0] bank_default(input int field, input int bank);
    logic odd;
    odd = (bank % 2) == 1;
    if (field == F_VSE) return odd ? 10'h001 : 10'h004;
    return odd ? 10'h26F : 10'h001;
  endfunction
endpackage

// File: rtl/vtr_ctrl.sv
module vtr_ctrl
  import vtr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [SEL_W-1:0] sel,
  output logic             sel_change,
  output logic [DW-1:0]    ofs
);
  logic sel_wr;
  logic ofs_wr;

  assign sel_wr     = wr_en && (addr == A_STD);
  assign ofs_wr     = wr_en && (addr == A_OFS);
  assign sel_change = sel_wr && (wdata[SEL_W-1:0] != sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
      ofs <= '0;
    end else begin
      if (sel_wr) sel <= wdata[SEL_W-1:0];
      if (ofs_wr) ofs <= wdata;
    end
  end
endmodule

// File: rtl/vtr_field.sv
module vtr_field
  import vtr_pkg::*;
#(
  parameter int             NBANKS  = 4,
  parameter int             SEL_W   = 2,
  parameter int             FIELD   = 0,
  parameter logic [DW-1:0]  LO_ADDR = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [SEL_W-1:0] sel,
  input  logic             flush,
  output logic [LW-1:0]    value
);
  localparam logic [DW-1:0] HI_ADDR = LO_ADDR + 8'd1;

  logic [DW-1:0] stage_q;
  logic          pend_q;
  logic          lo_wr;
  logic          hi_wr;
  logic [LW-1:0] bank_q [NBANKS];

  assign lo_wr = wr_en && (addr == LO_ADDR);
  assign hi_wr = wr_en && (addr == HI_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      pend_q  <= 1'b0;
    end else if (flush) begin
      pend_q  <= 1'b0;
    end else if (lo_wr) begin
      stage_q <= wdata;
      pend_q  <= 1'b1;
    end else if (hi_wr) begin
      pend_q  <= 1'b0;
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[b] <= bank_default(FIELD, b);
      end else if (hi_wr && (sel == SEL_W'(b))) begin
        bank_q[b] <= {wdata[LW-DW-1:0], pend_q ? stage_q : bank_q[b][DW-1:0]};
      end
    end
  end

  assign value = bank_q[sel];
endmodule

// File: rtl/vtr_regfile.sv
module vtr_regfile
  import vtr_pkg::*;
#(
  parameter int NBANKS = 4,
  localparam int SEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [SEL_W-1:0] std_sel,
  output logic [9:0]       vs_end_line,
  output logic [9:0]       vb_start_line,
  output logic [9:0]       vb_end_line,
  output logic [7:0]       sync_offset
);
  localparam logic [DW-1:0] LO_ADDRS [NFIELD] = '{A_VSE_LO, A_VBS_LO, A_VBE_LO};

  logic          sel_change;
  logic [LW-1:0] fval [NFIELD];

  vtr_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sel(std_sel), .sel_change(sel_change), .ofs(sync_offset)
  );

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    vtr_field #(
      .NBANKS(NBANKS), .SEL_W(SEL_W), .FIELD(f), .LO_ADDR(LO_ADDRS[f])
    ) u_field (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .sel(std_sel), .flush(sel_change), .value(fval[f])
    );
  end

  assign vs_end_line   = fval[F_VSE];
  assign vb_start_line = fval[F_VBS];
  assign vb_end_line   = fval[F_VBE];

  always_comb begin
    rdata = '0;
    if (addr == A_STD) rdata = DW'(std_sel);
    else if (addr == A_OFS) rdata = sync_offset;
    for (int f = 0; f < NFIELD; f++) begin
      if (addr == LO_ADDRS[f]) rdata = fval[f][DW-1:0];
      if (addr == LO_ADDRS[f] + 8'd1) rdata = {{(2*DW-LW){1'b0}}, fval[f][LW-1:DW]};
    end
  end
endmodule

// File: rtl/vtr_chk.sv
module vtr_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       addr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic [SEL_W-1:0] std_sel,
  input logic [9:0]       vs_end_line,
  input logic [9:0]       vb_start_line,
  input logic [9:0]       vb_end_line,
  input logic [7:0]       sync_offset
);
  logic hi_or_sel;
  assign hi_or_sel = wr_en && (addr == 8'h21 || addr == 8'h23 || addr == 8'h25 || addr == 8'h02);

  a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h02) |=> (std_sel == $past(wdata[SEL_W-1:0])));

  a_r3_hi_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h21) |=> (vs_end_line[9:8] == $past(wdata[1:0])));

  a_r4_lo_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 8'h20 || addr == 8'h22 || addr == 8'h24))
      |=> ($stable(vs_end_line) && $stable(vb_start_line) && $stable(vb_end_line)));

  a_r6_hi_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h21 || addr == 8'h23 || addr == 8'h25) |-> (rdata[7:2] == 6'd0));

  a_r7_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h26) |=> (sync_offset == $past(wdata)));

  a_r11_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_or_sel |=> ($stable(vs_end_line) && $stable(vb_start_line) && $stable(vb_end_line)));

  a_r11_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h26) |=> $stable(sync_offset));
endmodule

bind vtr_regfile vtr_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_vtr_regfile.sv
`timescale 1ns/1ps
module sim_vtr_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] std_sel;
  logic [9:0] vs_end_line, vb_start_line, vb_end_line;
  logic [7:0] sync_offset;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vtr_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .std_sel(std_sel), .vs_end_line(vs_end_line),
    .vb_start_line(vb_start_line), .vb_end_line(vb_end_line), .sync_offset(sync_offset)
  );

  // Behavioural reference: m_val[field][bank]
  int m_val [3][4];
  int m_stage [3];
  bit m_pend [3];
  int m_std;
  int m_ofs;

  function automatic int dflt(int f, int b);
    if (b % 2 == 1) return (f == 0) ? 'h001 : 'h26F;
    return (f == 0) ? 'h004 : 'h001;
  endfunction

  function automatic int m_read(int a);
    for (int f = 0; f < 3; f++) begin
      if (a == 'h20 + 2*f) return m_val[f][m_std] % 256;
      if (a == 'h21 + 2*f) return m_val[f][m_std] / 256;
    end
    if (a == 'h02) return m_std;
    if (a == 'h26) return m_ofs;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_std = 0; m_ofs = 0;
      for (int f = 0; f < 3; f++) begin
        m_stage[f] = 0; m_pend[f] = 0;
        for (int b = 0; b < 4; b++) m_val[f][b] = dflt(f, b);
      end
    end else if (wr_en) begin
      if (addr == 8'h02) begin
        if (int'(wdata[1:0]) != m_std) for (int f = 0; f < 3; f++) m_pend[f] = 0;
        m_std = int'(wdata[1:0]);
      end else if (addr == 8'h26) begin
        m_ofs = int'(wdata);
      end else begin
        for (int f = 0; f < 3; f++) begin
          if (int'(addr) == 'h20 + 2*f) begin
            m_stage[f] = int'(wdata); m_pend[f] = 1;
          end else if (int'(addr) == 'h21 + 2*f) begin
            m_val[f][m_std] = int'(wdata[1:0]) * 256 +
                              (m_pend[f] ? m_stage[f] : m_val[f][m_std] % 256);
            m_pend[f] = 0;
          end
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare every clock, half a period after the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1/R2 std_sel", int'(std_sel), m_std);
      check("R3/R4/R5/R8/R9/R11 vs_end_line", int'(vs_end_line), m_val[0][m_std]);
      check("R3/R4/R5/R8/R9/R11 vb_start_line", int'(vb_start_line), m_val[1][m_std]);
      check("R3/R4/R5/R8/R9/R11 vb_end_line", int'(vb_end_line), m_val[2][m_std]);
      check("R7/R11 sync_offset", int'(sync_offset), m_ofs);
      check("R6/R10 rdata", int'(rdata), m_read(int'(addr)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [7:0] a);
    @(posedge clk); #1;
    wr_en = 1'b0; addr = a; wdata = 8'h00;
  endtask

  bit done = 1'b0;
  initial begin
    #(100000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset defaults, read every mapped register
    for (int a = 'h20; a <= 'h26; a++) rd(8'(a));
    rd(8'h02);
    // R4 and R6: staging alone changes nothing, readback shows committed byte
    wr(8'h20, 8'h55); rd(8'h20);
    // R3: high byte commits, reserved bits dropped
    wr(8'h21, 8'hFE); rd(8'h20); rd(8'h21);
    // R2: select bank 1 (625-line defaults), upper bits ignored
    wr(8'h02, 8'hFD); rd(8'h02); rd(8'h23);
    // R5: change bank 1 only, then return to bank 0
    wr(8'h22, 8'h12); wr(8'h23, 8'h03); rd(8'h22);
    wr(8'h02, 8'h00); rd(8'h22); rd(8'h23);
    // R8: staged byte discarded on select change
    wr(8'h22, 8'h77); wr(8'h02, 8'h03); wr(8'h23, 8'h01); rd(8'h22);
    // R9: high byte with nothing staged keeps low byte
    wr(8'h25, 8'h02); rd(8'h24); rd(8'h25);
    // Same select rewritten: staged byte survives
    wr(8'h24, 8'hA5); wr(8'h02, 8'h03); wr(8'h25, 8'h00); rd(8'h24);
    // R7: signed offset extremes
    wr(8'h26, 8'h80); rd(8'h26); wr(8'h26, 8'h7F); wr(8'h26, 8'hFF); rd(8'h26);
    // R10: unmapped addresses
    wr(8'h30, 8'hAA); rd(8'h30); wr(8'h27, 8'h11); rd(8'h27); wr(8'h1F, 8'h33); rd(8'h00);
    // R5/R3 sweep: distinct values per bank and field
    for (int b = 0; b < 4; b++) begin
      wr(8'h02, 8'(b));
      for (int f = 0; f < 3; f++) begin
        wr(8'(8'h20 + 2*f), 8'(17*b + 5*f + 3));
        wr(8'(8'h21 + 2*f), 8'(b + f));
      end
    end
    for (int b = 0; b < 4; b++) begin
      wr(8'h02, 8'(b));
      for (int a = 'h20; a <= 'h26; a++) rd(8'(a));
    end
    // R11: idle cycles hold outputs
    repeat (4) rd(8'h02);
    // R1: reset again restores defaults
    @(posedge clk); #1 rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      wr(8'h02, 8'(b)); rd(8'h20); rd(8'h23); rd(8'h25);
    end
    rd(8'h00); rd(8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule